// File: doc/BRIEF.md
# Indirect Channel Descriptor Store

This block keeps DMA descriptors for a set of channels behind two registers on a 32-bit register bus: an address pointer and a data window. Software loads the pointer once and then streams words through the data window. Each data write stores one word and steps the pointer. Every channel owns two rows of five 32-bit words. In address space each row takes eight slots, and slots 5 to 7 hold no storage. A channel's descriptor starts at 0x10000 OR (channel << 4), and its second row starts 8 slots higher.

A downstream consumer selects a channel and reads back the frame width, height, line stride and buffer base address decoded from fixed fields. The block also holds per-channel control bits: buffer ready, current buffer, double-buffer mode and enable. The consumer reports a finished buffer with a done pulse. While a channel's ready bit is set, a write to that channel's buffer base word is refused and an error is flagged.

Top module: `chan_param_mem`

## Requirements
- R1: After reset, every stored word, the address pointer, all per-channel bit vectors and err_o are zero.
- R2: Register selects are: 0 address pointer, 1 data window, 2 ready, 3 current buffer, 4 double-buffer mode, 5 enable. Selects 6 and 7 read zero and ignore writes. A write to select 0 loads wdata[16:0] into the pointer, and reading select 0 returns it. Reading select 1 returns the word at the pointer and leaves the pointer unchanged.
- R3: A write to select 1 stores the word at the pointer and then adds 1 to the pointer. When the new low three bits equal 5, the low three bits are cleared and 8 is added instead. Word 4 of a channel's second row therefore continues at word 0 of the next channel.
- R4: A pointer slot with low bits 5 to 7, with bit 16 clear, or with a channel number (bits 15:4) at or above NUM_CH reads zero. A write there changes no stored word, but the pointer still advances.
- R5: The descriptor of channel c occupies pointer values 0x10000|(c<<4) (row 0, words 0-4) and that value + 8 (row 1, words 0-4).
- R6: For the channel on cons_ch_i, the consumer outputs are decoded as follows. Width is row 0 word 3 bits 23:12. Height is {row 0 word 4 bits 3:0, row 0 word 3 bits 31:24}. Stride is row 1 word 2 bits 16:3. Base is row 1 word 0. Both row fields hold value minus one.
- R7: A ready write sets each channel bit whose wdata bit is 1. A cons_done_i bit clears that channel's ready bit. When both happen in the same cycle, the set wins.
- R8: A data write to row 1 word 0 of a channel whose ready bit is set leaves the stored word unchanged. It drives err_o high for exactly the following cycle, and the pointer still advances. Every other data write leaves err_o low.
- R9: A current-buffer write with a 1 in a channel's bit clears that bit to buffer 0, and this takes priority over a done pulse. On cons_done_i, the current bit toggles if the channel's double-buffer bit is set and goes to 0 if it is clear.
- R10: The double-buffer mode and enable registers are plain read/write per-channel vectors, exposed on en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| err_o | output | 1 | One-cycle flag for a refused base write |
| cons_ch_i | input | CHW | Consumer channel select |
| cons_done_i | input | NUM_CH | Per-channel buffer-done pulses |
| cons_width_o | output | 12 | Frame width minus one |
| cons_height_o | output | 12 | Frame height minus one |
| cons_stride_o | output | 14 | Line stride minus one |
| cons_base_o | output | 32 | Buffer base address |
| rdy_o | output | NUM_CH | Buffer-ready bits |
| cur_buf_o | output | NUM_CH | Current-buffer bits |
| en_o | output | NUM_CH | Channel enable bits |

## Verification
The bench builds the block with NUM_CH = 4. With this value the last channel's descriptor ends at pointer 0x1003C, and one more data write steps the pointer to channel 4, which does not exist. Both the cross-channel row skip and the out-of-range refusal can therefore be reached in a few writes. The small channel count also lets the bench check every per-channel vector in full, including the same-cycle set and done case and the toggle of the current buffer in double-buffer mode.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int ADDR_W   = 17;
  localparam int WORD_W   = 32;
  localparam int ROW_WDS  = 5;
  localparam int CH_WDS   = 2 * ROW_WDS;

  localparam logic [2:0] SEL_ADDR = 3'd0;
  localparam logic [2:0] SEL_DATA = 3'd1;
  localparam logic [2:0] SEL_RDY  = 3'd2;
  localparam logic [2:0] SEL_CUR  = 3'd3;
  localparam logic [2:0] SEL_DB   = 3'd4;
  localparam logic [2:0] SEL_EN   = 3'd5;

  // Step the pointer, jumping over the three empty slots at the end of a row.
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] n;
    n = a + 1'b1;
    if (n[2:0] == 3'd5) n = {n[ADDR_W-1:3] + 1'b1, 3'b000};
    return n;
  endfunction
endpackage

// File: rtl/cpm_addr_dec.sv
module cpm_addr_dec import cpm_pkg::*; #(
  parameter int NUM_CH = 32,
  localparam int CHW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDXW = $clog2(NUM_CH * CH_WDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              is_base_o,
  output logic [CHW-1:0]    ch_o,
  output logic [IDXW-1:0]   idx_o
);
  logic [11:0] ch_full;
  assign ch_full   = addr_i[15:4];
  assign hit_o     = addr_i[16] && (int'(ch_full) < NUM_CH) && (addr_i[2:0] < 3'd5);
  assign is_base_o = addr_i[3] && (addr_i[2:0] == 3'd0);
  assign ch_o      = CHW'(ch_full);
  assign idx_o     = IDXW'(int'(ch_full) * CH_WDS + (addr_i[3] ? ROW_WDS : 0) + int'(addr_i[2:0]));
endmodule

// File: rtl/cpm_store.sv
module cpm_store import cpm_pkg::*; #(
  parameter int NUM_CH = 32,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NWORD = NUM_CH * CH_WDS,
  localparam int IDXW  = $clog2(NWORD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDXW-1:0]   idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [CHW-1:0]    cons_ch_i,
  output logic [11:0]       width_o,
  output logic [11:0]       height_o,
  output logic [13:0]       stride_o,
  output logic [31:0]       base_o
);
  logic [WORD_W-1:0] mem_q [NWORD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORD; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  logic [WORD_W-1:0] w3, w4, w5, w7;
  always_comb begin
    w3 = '0; w4 = '0; w5 = '0; w7 = '0;
    if (int'(cons_ch_i) < NUM_CH) begin
      w3 = mem_q[IDXW'(int'(cons_ch_i) * CH_WDS + 3)];
      w4 = mem_q[IDXW'(int'(cons_ch_i) * CH_WDS + 4)];
      w5 = mem_q[IDXW'(int'(cons_ch_i) * CH_WDS + 5)];
      w7 = mem_q[IDXW'(int'(cons_ch_i) * CH_WDS + 7)];
    end
  end

  assign width_o  = w3[23:12];
  assign height_o = {w4[3:0], w3[31:24]};
  assign stride_o = w7[16:3];
  assign base_o   = w5;
endmodule

// File: rtl/cpm_chan_bits.sv
module cpm_chan_bits import cpm_pkg::*; #(
  parameter int NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        sel_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] rdy_o,
  output logic [NUM_CH-1:0] cur_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] db_o
);
  logic [NUM_CH-1:0] rdy_q, cur_q, en_q, db_q;
  logic [NUM_CH-1:0] rdy_set, cur_clr, cur_n;

  assign rdy_set = (wr_i && sel_i == SEL_RDY) ? wdata_i : '0;
  assign cur_clr = (wr_i && sel_i == SEL_CUR) ? wdata_i : '0;
  // done: toggle in double-buffer mode, otherwise fall back to buffer 0
  assign cur_n   = ((cur_q & ~done_i) | (done_i & db_q & ~cur_q)) & ~cur_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= '0;
      cur_q <= '0;
      en_q  <= '0;
      db_q  <= '0;
    end else begin
      rdy_q <= (rdy_q & ~done_i) | rdy_set;
      cur_q <= cur_n;
      if (wr_i && sel_i == SEL_EN) en_q <= wdata_i;
      if (wr_i && sel_i == SEL_DB) db_q <= wdata_i;
    end
  end

  assign rdy_o = rdy_q;
  assign cur_o = cur_q;
  assign en_o  = en_q;
  assign db_o  = db_q;
endmodule

// File: rtl/chan_param_mem.sv
module chan_param_mem import cpm_pkg::*; #(
  parameter int NUM_CH = 32,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDXW  = $clog2(NUM_CH * CH_WDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              err_o,
  input  logic [CHW-1:0]    cons_ch_i,
  input  logic [NUM_CH-1:0] cons_done_i,
  output logic [11:0]       cons_width_o,
  output logic [11:0]       cons_height_o,
  output logic [13:0]       cons_stride_o,
  output logic [31:0]       cons_base_o,
  output logic [NUM_CH-1:0] rdy_o,
  output logic [NUM_CH-1:0] cur_buf_o,
  output logic [NUM_CH-1:0] en_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              hit, is_base, data_wr, refuse, err_q;
  logic [CHW-1:0]    ch;
  logic [IDXW-1:0]   idx;
  logic [WORD_W-1:0] mem_rd;
  logic [NUM_CH-1:0] db_q;

  cpm_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i(addr_q), .hit_o(hit), .is_base_o(is_base), .ch_o(ch), .idx_o(idx)
  );

  assign data_wr = reg_wr_i && (reg_sel_i == SEL_DATA);
  assign refuse  = data_wr && hit && is_base && rdy_o[ch];

  cpm_store #(.NUM_CH(NUM_CH)) u_store (
    .clk_i, .rst_ni,
    .we_i(data_wr && hit && !refuse), .idx_i(idx), .wdata_i(reg_wdata_i),
    .rdata_o(mem_rd), .cons_ch_i,
    .width_o(cons_width_o), .height_o(cons_height_o),
    .stride_o(cons_stride_o), .base_o(cons_base_o)
  );

  cpm_chan_bits #(.NUM_CH(NUM_CH)) u_bits (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i[NUM_CH-1:0]), .done_i(cons_done_i),
    .rdy_o, .cur_o(cur_buf_o), .en_o, .db_o(db_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= refuse;
      if (reg_wr_i && reg_sel_i == SEL_ADDR) addr_q <= reg_wdata_i[ADDR_W-1:0];
      else if (data_wr)                      addr_q <= next_addr(addr_q);
    end
  end

  assign err_o = err_q;

  always_comb begin
    unique case (reg_sel_i)
      SEL_ADDR: reg_rdata_o = 32'(addr_q);
      SEL_DATA: reg_rdata_o = hit ? mem_rd : '0;
      SEL_RDY:  reg_rdata_o = 32'(rdy_o);
      SEL_CUR:  reg_rdata_o = 32'(cur_buf_o);
      SEL_DB:   reg_rdata_o = 32'(db_q);
      SEL_EN:   reg_rdata_o = 32'(en_o);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cpm_chk.sv
module cpm_chk import cpm_pkg::*; #(
  parameter int NUM_CH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [2:0]        reg_sel_i,
  input logic [ADDR_W-1:0] addr_q,
  input logic              err_o,
  input logic [NUM_CH-1:0] rdy_o,
  input logic [NUM_CH-1:0] cur_buf_o,
  input logic [NUM_CH-1:0] en_o,
  input logic [NUM_CH-1:0] db_q,
  input logic [NUM_CH-1:0] cons_done_i
);
  AST_ROW_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i == SEL_DATA && addr_q[2:0] == 3'd4) |=> addr_q[2:0] == 3'd0); // R3
  AST_ERR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(reg_wr_i && reg_sel_i == SEL_DATA && rdy_o != '0)); // R8
  AST_RDY_RISE_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdy_o & ~$past(rdy_o)) != '0) |-> $past(reg_wr_i && reg_sel_i == SEL_RDY)); // R7
  AST_DONE_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_wr_i) |-> ((rdy_o & $past(cons_done_i)) == '0)); // R7
  AST_CUR_NEEDS_DB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur_buf_o & ~$past(cur_buf_o) & ~$past(db_q)) == '0)); // R9
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_wr_i && reg_sel_i == SEL_EN) |-> $stable(en_o)); // R10
endmodule

bind chan_param_mem cpm_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
  .addr_q(addr_q), .err_o(err_o), .rdy_o(rdy_o), .cur_buf_o(cur_buf_o),
  .en_o(en_o), .db_q(db_q), .cons_done_i(cons_done_i)
);

// File: tb/tb_chan_param_mem.sv
`timescale 1ns/1ps
module tb_chan_param_mem;
  localparam int NCH = 4;
  localparam logic [2:0] S_ADDR = 3'd0, S_DATA = 3'd1, S_RDY = 3'd2,
                         S_CUR = 3'd3, S_DB = 3'd4, S_EN = 3'd5;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic err;
  logic [1:0] cons_ch = 0;
  logic [NCH-1:0] cons_done = 0, rdy, cur, en;
  logic [11:0] c_w, c_h;
  logic [13:0] c_s;
  logic [31:0] c_b;

  int tests = 0, fails = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  chan_param_mem #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .err_o(err),
    .cons_ch_i(cons_ch), .cons_done_i(cons_done), .cons_width_o(c_w),
    .cons_height_o(c_h), .cons_stride_o(c_s), .cons_base_o(c_b),
    .rdy_o(rdy), .cur_buf_o(cur), .en_o(en)
  );

  // {check, sel, data}: check=0 writes data, check=1 compares readback to data
  localparam logic [35:0] VEC [19] = '{
    {1'b0, S_ADDR, 32'h0001_0010},   // R5 channel 1 row 0
    {1'b1, S_ADDR, 32'h0001_0010},   // R2
    {1'b0, S_DATA, 32'h0000_00A0},
    {1'b0, S_DATA, 32'h0000_00A1},
    {1'b0, S_DATA, 32'h0000_00A2},
    {1'b0, S_DATA, 32'h5F0A_B000},
    {1'b0, S_DATA, 32'h0000_0003},
    {1'b1, S_ADDR, 32'h0001_0018},   // R3 skip to row 1
    {1'b0, S_DATA, 32'h8000_1000},
    {1'b0, S_DATA, 32'h0000_00B1},
    {1'b0, S_DATA, 32'h0000_09F8},
    {1'b1, S_ADDR, 32'h0001_001B},
    {1'b0, S_ADDR, 32'h0001_0013},
    {1'b1, S_DATA, 32'h5F0A_B000},   // R2 R3
    {1'b1, S_ADDR, 32'h0001_0013},   // R2 read holds pointer
    {1'b0, S_ADDR, 32'h0001_0018},
    {1'b1, S_DATA, 32'h8000_1000},   // R5
    {1'b0, S_ADDR, 32'h0001_0010},
    {1'b1, S_DATA, 32'h0000_00A0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    reg_sel = sel;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    cons_done = m;
    @(negedge clk);
    cons_done = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 8; s++) rd_chk("R1 reg", 3'(s), 32'h0);
    chk("R1 err", 32'(err), 0);
    chk("R1 vectors", {20'h0, rdy, cur, en}, 0);
    chk("R1 base", c_b, 0);

    for (int i = 0; i < 19; i++) begin
      if (VEC[i][35]) rd_chk("R2/R3 table", VEC[i][34:32], VEC[i][31:0]);
      else wr(VEC[i][34:32], VEC[i][31:0]);
    end

    // R6 consumer decode of channel 1
    cons_ch = 1; #1;
    chk("R6 width", 32'(c_w), 32'h0AB);
    chk("R6 height", 32'(c_h), 32'h35F);
    chk("R6 stride", 32'(c_s), 32'h13F);
    chk("R6 base", c_b, 32'h8000_1000);
    cons_ch = 0; #1;
    chk("R6 other channel", c_b, 0);

    // R4 empty slot
    wr(S_ADDR, 32'h0001_0015);
    wr(S_DATA, 32'hFFFF_FFFF);
    rd_chk("R4 slot5 advances", S_ADDR, 32'h0001_0016);
    wr(S_ADDR, 32'h0001_0015);
    rd_chk("R4 slot5 reads zero", S_DATA, 0);
    wr(S_ADDR, 32'h0001_0014);
    rd_chk("R4 word4 intact", S_DATA, 32'h3);
    wr(S_ADDR, 32'h0001_0017);
    wr(S_DATA, 32'h1234);
    rd_chk("R3 slot7 next row", S_ADDR, 32'h0001_0018);
    rd_chk("R4 base intact", S_DATA, 32'h8000_1000);

    // R3 row 1 word 4 rolls into next channel
    wr(S_ADDR, 32'h0001_001C);
    wr(S_DATA, 32'h77);
    rd_chk("R3 channel wrap", S_ADDR, 32'h0001_0020);
    wr(S_ADDR, 32'h0001_001C);
    rd_chk("R3 wrap store", S_DATA, 32'h77);

    // R4 out of range channel and missing bit 16
    wr(S_ADDR, 32'h0001_0040);
    wr(S_DATA, 32'h55);
    rd_chk("R4 oob advance", S_ADDR, 32'h0001_0041);
    wr(S_ADDR, 32'h0001_0040);
    rd_chk("R4 oob reads zero", S_DATA, 0);
    wr(S_ADDR, 32'h0001_0000);
    rd_chk("R4 ch0 untouched", S_DATA, 0);
    wr(S_ADDR, 32'h0000_0010);
    rd_chk("R4 bit16 clear", S_DATA, 0);

    // R7 ready set, R8 refused base write
    wr(S_RDY, 32'h2);
    rd_chk("R7 ready set", S_RDY, 32'h2);
    chk("R7 rdy_o", 32'(rdy), 32'h2);
    wr(S_ADDR, 32'h0001_0018);
    wr(S_DATA, 32'h1234_5678);
    chk("R8 err high", 32'(err), 1);
    @(negedge clk);
    chk("R8 err one cycle", 32'(err), 0);
    rd_chk("R8 pointer advanced", S_ADDR, 32'h0001_0019);
    cons_ch = 1; #1;
    chk("R8 base kept", c_b, 32'h8000_1000);
    wr(S_DATA, 32'hC1);
    chk("R8 non-base no err", 32'(err), 0);
    wr(S_ADDR, 32'h0001_0019);
    rd_chk("R8 non-base stored", S_DATA, 32'hC1);
    pulse(4'b0010);
    chk("R7 done clears", 32'(rdy), 0);
    wr(S_ADDR, 32'h0001_0018);
    wr(S_DATA, 32'hDEAD_0000);
    chk("R8 accepted no err", 32'(err), 0);
    chk("R8 accepted base", c_b, 32'hDEAD_0000);
    @(negedge clk);
    reg_wr = 1; reg_sel = S_RDY; reg_wdata = 32'h2; cons_done = 4'b0010;
    @(negedge clk);
    reg_wr = 0; cons_done = 0;
    chk("R7 set wins", 32'(rdy), 32'h2);
    pulse(4'b0011);
    chk("R7 done clear", 32'(rdy), 0);

    // R9 current buffer
    pulse(4'b0010);
    chk("R9 single buffer stays 0", 32'(cur), 0);
    wr(S_DB, 32'h2);
    rd_chk("R10 db readback", S_DB, 32'h2);
    pulse(4'b0010);
    chk("R9 toggle to 1", 32'(cur), 32'h2);
    pulse(4'b0010);
    chk("R9 toggle to 0", 32'(cur), 0);
    pulse(4'b0010);
    rd_chk("R9 cur read", S_CUR, 32'h2);
    wr(S_CUR, 32'h2);
    chk("R9 write1 clears", 32'(cur), 0);
    pulse(4'b0010);
    wr(S_DB, 32'h0);
    pulse(4'b0010);
    chk("R9 db off back to 0", 32'(cur), 0);

    // R10 enable
    wr(S_EN, 32'h5);
    rd_chk("R10 en read", S_EN, 32'h5);
    chk("R10 en_o", 32'(en), 32'h5);
    wr(S_EN, 32'hA);
    chk("R10 en_o rewrite", 32'(en), 32'hA);
    wr(3'd6, 32'hF);
    rd_chk("R2 sel6 zero", 3'd6, 0);
    chk("R2 sel6 ignored", 32'(en), 32'hA);

    finish_run();
  end
endmodule